// File: doc/BRIEF.md
# Debug Event Qualifier

This block sits behind the breakpoint and watchpoint address comparators of a processor core. Each comparator slot supplies a raw hit flag. Each slot also has a control word that says in which privilege levels and in which security state the slot may fire, and whether it must also be confirmed by a context match on another slot. The block applies those rules, together with a global debug enable and a "debug exceptions can be taken now" input. It raises one breakpoint event and one watchpoint event, each with the index of the lowest slot that qualified.

Breakpoint slots and watchpoint slots use one control word layout:
- privilege mask: bit 1 allows level 1, bit 2 allows level 0;
- higher-level enable: bit 13;
- security selector: bits 15:14;
- linked slot number: bits 19:16;
- link enable: bit 20.

The result of the context matcher comes in as one flag per breakpoint slot. A linked slot reads the flag of the slot its link field names. Results are registered, so an event appears one clock after the inputs that cause it.

Top module: `dbgq_top`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, `bp_event`, `wp_event`, `bp_idx` and `wp_idx` are all 0.
- R2: Security selector (bits 15:14) = 0 places no constraint. A value of 1 or 3 rejects the hit when `secure` = 1. A value of 2 rejects the hit when `secure` = 0.
- R3: At `cur_el` = 2 or 3 a hit requires bit 13 = 1. At `cur_el` = 1 it requires bit 1 = 1. At `cur_el` = 0 it requires bit 2 = 1.
- R4: When `wp_unpriv` = 1, watchpoint slots apply the privilege check of level 0 whatever `cur_el` holds. Breakpoint slots ignore `wp_unpriv`.
- R5: When bit 20 is set, the hit qualifies only if the link field (bits 19:16) names a slot below NUM_SLOTS whose `ctx_match` bit is 1. A link field at or above NUM_SLOTS rejects the hit.
- R6: When bit 15 of `dbg_ctrl` is 0, or when `dbg_allowed` is 0, neither event is raised.
- R7: Each event is 1 when at least one slot of its kind has a raw hit that passes every rule. Its index is the lowest such slot.
- R8: A `cur_el` value above 3 qualifies no slot.
- R9: Outputs change one clock after the inputs that cause them. An index output is 0 whenever its event is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bp_hit | input | NUM_SLOTS | Raw address hit per breakpoint slot |
| wp_hit | input | NUM_SLOTS | Raw address hit per watchpoint slot |
| bp_ctrl | input | NUM_SLOTS*CTRL_W | Breakpoint control words, slot 0 in the low bits |
| wp_ctrl | input | NUM_SLOTS*CTRL_W | Watchpoint control words, slot 0 in the low bits |
| cur_el | input | EL_W | Current privilege level |
| secure | input | 1 | Current security state, 1 = secure |
| wp_unpriv | input | 1 | Data access comes from an unprivileged load/store |
| dbg_ctrl | input | CTRL_W | Monitor debug control word, bit 15 = global enable |
| dbg_allowed | input | 1 | Debug exceptions may be taken now |
| ctx_match | input | NUM_SLOTS | Context matcher result per breakpoint slot |
| bp_event | output | 1 | Breakpoint event |
| bp_idx | output | IDX_W | Lowest qualified breakpoint slot |
| wp_event | output | 1 | Watchpoint event |
| wp_idx | output | IDX_W | Lowest qualified watchpoint slot |

## Verification
Directed patterns sweep each security-selector value against both security states, and each privilege level against masks that allow only one level. This separates a swapped mask bit or a reversed selector from a correct decode. An unprivileged access at level 2 with only the level-0 bit set tells the substitution apart from a plain level check, and the same pattern on a breakpoint slot shows that breakpoints ignore it. Linked slots are tried with a matching flag, a missing flag and a link field past the last slot. Several simultaneous hits, where the lower slots are rejected by different rules, check that the index follows qualification and not the raw hit. Random control words, levels and gates then cover mixed combinations.

// File: rtl/dbgq_pkg.sv
package dbgq_pkg;
  localparam int FLD_PRIV_LO  = 1;
  localparam int FLD_PRIV_HI  = 2;
  localparam int FLD_HIGHER   = 13;
  localparam int FLD_SEC_LO   = 14;
  localparam int FLD_SEC_HI   = 15;
  localparam int FLD_LINK_LO  = 16;
  localparam int LINK_W       = 4;
  localparam int FLD_LINK_EN  = 20;
  localparam int FLD_GLOBAL   = 15;
  localparam int MIN_CTRL_W   = 21;

  typedef enum logic [1:0] {
    SEC_ANY    = 2'd0,
    SEC_NS_A   = 2'd1,
    SEC_ONLY_S = 2'd2,
    SEC_NS_B   = 2'd3
  } sec_sel_e;

  typedef struct packed {
    logic              priv_l0;
    logic              priv_l1;
    logic              higher;
    sec_sel_e          sec_sel;
    logic [LINK_W-1:0] link_slot;
    logic              link_en;
  } slot_fields_t;

  function automatic slot_fields_t unpack_fields(input logic [MIN_CTRL_W-1:0] w);
    slot_fields_t f;
    f.priv_l1   = w[FLD_PRIV_LO];
    f.priv_l0   = w[FLD_PRIV_HI];
    f.higher    = w[FLD_HIGHER];
    f.sec_sel   = sec_sel_e'(w[FLD_SEC_HI:FLD_SEC_LO]);
    f.link_slot = w[FLD_LINK_LO +: LINK_W];
    f.link_en   = w[FLD_LINK_EN];
    return f;
  endfunction
endpackage

// File: rtl/dbgq_slot_rules.sv
module dbgq_slot_rules
  import dbgq_pkg::*;
#(
  parameter int NUM_SLOTS = 6,
  parameter int CTRL_W    = 32,
  parameter int EL_W      = 3,
  parameter bit IS_DATA   = 1'b0
) (
  input  logic                 raw_hit,
  input  logic [CTRL_W-1:0]    ctrl,
  input  logic [EL_W-1:0]      cur_el,
  input  logic                 secure,
  input  logic                 unpriv,
  input  logic [NUM_SLOTS-1:0] ctx_match,
  output logic                 qualified
);
  slot_fields_t f;
  logic el_valid;
  logic [1:0] eff_el;
  logic sec_ok;
  logic priv_ok;
  logic link_ok;
  logic link_sel;

  always_comb begin
    f        = unpack_fields(ctrl[MIN_CTRL_W-1:0]);
    el_valid = (cur_el <= EL_W'(3));
    eff_el   = cur_el[1:0];
    if (IS_DATA && unpriv) eff_el = 2'd0;

    unique case (f.sec_sel)
      SEC_ANY:            sec_ok = 1'b1;
      SEC_ONLY_S:         sec_ok = secure;
      SEC_NS_A, SEC_NS_B: sec_ok = !secure;
      default:            sec_ok = 1'b0;
    endcase

    unique case (eff_el)
      2'd0:       priv_ok = f.priv_l0;
      2'd1:       priv_ok = f.priv_l1;
      2'd2, 2'd3: priv_ok = f.higher;
      default:    priv_ok = 1'b0;
    endcase

    link_sel = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (f.link_slot == LINK_W'(i)) link_sel = ctx_match[i];
    end
    link_ok = !f.link_en || link_sel;

    qualified = raw_hit && el_valid && sec_ok && priv_ok && link_ok;
  end
endmodule

// File: rtl/dbgq_lowest.sv
module dbgq_lowest #(
  parameter int NUM_SLOTS = 6,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] req,
  output logic                 any,
  output logic [IDX_W-1:0]     idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/dbgq_top.sv
module dbgq_top
  import dbgq_pkg::*;
#(
  parameter int NUM_SLOTS = 6,
  parameter int CTRL_W    = 32,
  parameter int EL_W      = 3,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_SLOTS-1:0]        bp_hit,
  input  logic [NUM_SLOTS-1:0]        wp_hit,
  input  logic [NUM_SLOTS*CTRL_W-1:0] bp_ctrl,
  input  logic [NUM_SLOTS*CTRL_W-1:0] wp_ctrl,
  input  logic [EL_W-1:0]             cur_el,
  input  logic                        secure,
  input  logic                        wp_unpriv,
  input  logic [CTRL_W-1:0]           dbg_ctrl,
  input  logic                        dbg_allowed,
  input  logic [NUM_SLOTS-1:0]        ctx_match,
  output logic                        bp_event,
  output logic [IDX_W-1:0]            bp_idx,
  output logic                        wp_event,
  output logic [IDX_W-1:0]            wp_idx
);
  logic [NUM_SLOTS-1:0] bp_q;
  logic [NUM_SLOTS-1:0] wp_q;
  logic gate_open;
  logic bp_any, wp_any;
  logic [IDX_W-1:0] bp_sel, wp_sel;

  assign gate_open = dbg_ctrl[FLD_GLOBAL] && dbg_allowed;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    dbgq_slot_rules #(
      .NUM_SLOTS(NUM_SLOTS), .CTRL_W(CTRL_W), .EL_W(EL_W), .IS_DATA(1'b0)
    ) u_bp (
      .raw_hit  (bp_hit[s]),
      .ctrl     (bp_ctrl[s*CTRL_W +: CTRL_W]),
      .cur_el   (cur_el),
      .secure   (secure),
      .unpriv   (wp_unpriv),
      .ctx_match(ctx_match),
      .qualified(bp_q[s])
    );
    dbgq_slot_rules #(
      .NUM_SLOTS(NUM_SLOTS), .CTRL_W(CTRL_W), .EL_W(EL_W), .IS_DATA(1'b1)
    ) u_wp (
      .raw_hit  (wp_hit[s]),
      .ctrl     (wp_ctrl[s*CTRL_W +: CTRL_W]),
      .cur_el   (cur_el),
      .secure   (secure),
      .unpriv   (wp_unpriv),
      .ctx_match(ctx_match),
      .qualified(wp_q[s])
    );
  end

  dbgq_lowest #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_bp_pick (
    .req(bp_q), .any(bp_any), .idx(bp_sel)
  );
  dbgq_lowest #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_wp_pick (
    .req(wp_q), .any(wp_any), .idx(wp_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_event <= 1'b0;
      bp_idx   <= '0;
      wp_event <= 1'b0;
      wp_idx   <= '0;
    end else begin
      bp_event <= gate_open && bp_any;
      bp_idx   <= (gate_open && bp_any) ? bp_sel : '0;
      wp_event <= gate_open && wp_any;
      wp_idx   <= (gate_open && wp_any) ? wp_sel : '0;
    end
  end
endmodule

// File: rtl/dbgq_checker.sv
module dbgq_checker #(
  parameter int NUM_SLOTS = 6,
  parameter int CTRL_W    = 32,
  parameter int EL_W      = 3,
  parameter int IDX_W     = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_SLOTS-1:0] bp_hit,
  input logic [NUM_SLOTS-1:0] wp_hit,
  input logic [EL_W-1:0]      cur_el,
  input logic [CTRL_W-1:0]    dbg_ctrl,
  input logic                 dbg_allowed,
  input logic                 bp_event,
  input logic [IDX_W-1:0]     bp_idx,
  input logic                 wp_event,
  input logic [IDX_W-1:0]     wp_idx
);
  logic [NUM_SLOTS-1:0] bp_hit_d, wp_hit_d;
  always_ff @(posedge clk) begin
    bp_hit_d <= bp_hit;
    wp_hit_d <= wp_hit;
  end

  p_gate_r6: assert property (@(posedge clk) disable iff (rst)
    !(dbg_ctrl[15] && dbg_allowed) |=> (!bp_event && !wp_event));

  p_bad_level_r8: assert property (@(posedge clk) disable iff (rst)
    (cur_el > EL_W'(3)) |=> (!bp_event && !wp_event));

  p_no_raw_r7: assert property (@(posedge clk) disable iff (rst)
    (bp_hit == '0) |=> !bp_event);

  p_idx_raw_bp_r7: assert property (@(posedge clk) disable iff (rst)
    bp_event |-> bp_hit_d[bp_idx]);

  p_idx_raw_wp_r7: assert property (@(posedge clk) disable iff (rst)
    wp_event |-> wp_hit_d[wp_idx]);

  p_idx_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!bp_event |-> bp_idx == '0) and (!wp_event |-> wp_idx == '0));

  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (!bp_event && !wp_event));
endmodule

bind dbgq_top dbgq_checker #(
  .NUM_SLOTS(NUM_SLOTS), .CTRL_W(CTRL_W), .EL_W(EL_W), .IDX_W(IDX_W)
) u_dbgq_checker (
  .clk(clk), .rst(rst), .bp_hit(bp_hit), .wp_hit(wp_hit), .cur_el(cur_el),
  .dbg_ctrl(dbg_ctrl), .dbg_allowed(dbg_allowed), .bp_event(bp_event),
  .bp_idx(bp_idx), .wp_event(wp_event), .wp_idx(wp_idx)
);

// File: tb/dbgq_top_bench.sv
`timescale 1ns/1ps
module dbgq_top_bench;
  localparam int N  = 6;
  localparam int CW = 32;
  localparam int EW = 3;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] bp_hit = '0, wp_hit = '0, ctx_match = '0;
  logic [N*CW-1:0] bp_ctrl = '0, wp_ctrl = '0;
  logic [EW-1:0] cur_el = '0;
  logic secure = 1'b0, wp_unpriv = 1'b0, dbg_allowed = 1'b1;
  logic [CW-1:0] dbg_ctrl = 32'h0000_8000;
  logic bp_event, wp_event;
  logic [IW-1:0] bp_idx, wp_idx;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dbgq_top #(.NUM_SLOTS(N), .CTRL_W(CW), .EL_W(EW)) u_dbgq_top (
    .clk(clk), .rst(rst), .bp_hit(bp_hit), .wp_hit(wp_hit),
    .bp_ctrl(bp_ctrl), .wp_ctrl(wp_ctrl), .cur_el(cur_el), .secure(secure),
    .wp_unpriv(wp_unpriv), .dbg_ctrl(dbg_ctrl), .dbg_allowed(dbg_allowed),
    .ctx_match(ctx_match), .bp_event(bp_event), .bp_idx(bp_idx),
    .wp_event(wp_event), .wp_idx(wp_idx)
  );

  function automatic logic [CW-1:0] mk(input bit l0, input bit l1, input bit hi,
                                       input int sec, input int lnk, input bit len);
    logic [CW-1:0] w = '0;
    w[2] = l0; w[1] = l1; w[13] = hi;
    w[15:14] = 2'(sec); w[19:16] = 4'(lnk); w[20] = len;
    return w;
  endfunction

  function automatic bit slot_pass(input logic [CW-1:0] c, input bit data);
    int lvl;
    int sel;
    int ln;
    if (cur_el > 3) return 0;
    lvl = (data && wp_unpriv) ? 0 : int'(cur_el);
    sel = int'(c[15:14]);
    if (sel == 2 && !secure) return 0;
    if ((sel == 1 || sel == 3) && secure) return 0;
    if (lvl == 0 && !c[2]) return 0;
    if (lvl == 1 && !c[1]) return 0;
    if (lvl >= 2 && !c[13]) return 0;
    if (c[20]) begin
      ln = int'(c[19:16]);
      if (ln >= N) return 0;
      if (!ctx_match[ln]) return 0;
    end
    return 1;
  endfunction

  task automatic expect_side(input bit data, output bit ev, output int ix);
    ev = 0; ix = 0;
    if (!(dbg_ctrl[15] && dbg_allowed)) return;
    for (int s = 0; s < N; s++) begin
      if (!ev && (data ? wp_hit[s] : bp_hit[s]) &&
          slot_pass(data ? wp_ctrl[s*CW +: CW] : bp_ctrl[s*CW +: CW], data)) begin
        ev = 1; ix = s;
      end
    end
  endtask

  task automatic step_check(input string tag);
    bit be, we;
    int bi, wi;
    expect_side(0, be, bi);
    expect_side(1, we, wi);
    @(negedge clk);
    total++;
    if (bp_event !== be || int'(bp_idx) != bi) begin
      bad++;
      $display("FAIL %s bp: got ev=%0b idx=%0d exp ev=%0b idx=%0d", tag, bp_event, bp_idx, be, bi);
    end
    total++;
    if (wp_event !== we || int'(wp_idx) != wi) begin
      bad++;
      $display("FAIL %s wp: got ev=%0b idx=%0d exp ev=%0b idx=%0d", tag, wp_event, wp_idx, we, wi);
    end
  endtask

  task automatic one_slot(input int s, input logic [CW-1:0] c);
    bp_hit = '0; wp_hit = '0; bp_ctrl = '0; wp_ctrl = '0;
    bp_hit[s] = 1; wp_hit[s] = 1;
    bp_ctrl[s*CW +: CW] = c; wp_ctrl[s*CW +: CW] = c;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got no finish, exp finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    bp_hit = '1; wp_hit = '1;
    bp_ctrl = '1; wp_ctrl = '1; ctx_match = '1; cur_el = 1;
    repeat (3) @(negedge clk);
    total++;
    if (bp_event !== 0 || wp_event !== 0 || bp_idx !== 0 || wp_idx !== 0) begin
      bad++;
      $display("FAIL R1: got %0b%0b idx %0d %0d exp 00 idx 0 0", bp_event, wp_event, bp_idx, wp_idx);
    end
    rst = 0;
    bp_hit = '0; wp_hit = '0;
    @(negedge clk);
    total++;
    if (bp_event !== 0 || wp_event !== 0) begin
      bad++;
      $display("FAIL R1: after release got %0b%0b exp 00", bp_event, wp_event);
    end

    // R2 selector against both states
    cur_el = 1;
    for (int sec = 0; sec < 4; sec++) begin
      for (int st = 0; st < 2; st++) begin
        secure = st[0];
        one_slot(2, mk(1, 1, 1, sec, 0, 0));
        step_check("R2");
      end
    end
    secure = 0;

    // R3 each level with single-level masks
    for (int el = 0; el < 4; el++) begin
      cur_el = EW'(el);
      one_slot(1, mk(1, 0, 0, 0, 0, 0)); step_check("R3");
      one_slot(1, mk(0, 1, 0, 0, 0, 0)); step_check("R3");
      one_slot(1, mk(0, 0, 1, 0, 0, 0)); step_check("R3");
    end

    // R4 unprivileged data access at level 2
    cur_el = 2; wp_unpriv = 1;
    one_slot(3, mk(1, 0, 0, 0, 0, 0)); step_check("R4");
    one_slot(3, mk(0, 0, 1, 0, 0, 0)); step_check("R4");
    wp_unpriv = 0;

    // R5 linking
    cur_el = 1;
    ctx_match = 6'b010000;
    one_slot(0, mk(1, 1, 1, 0, 4, 1)); step_check("R5");
    one_slot(0, mk(1, 1, 1, 0, 3, 1)); step_check("R5");
    ctx_match = '1;
    one_slot(0, mk(1, 1, 1, 0, 7, 1)); step_check("R5");
    one_slot(0, mk(1, 1, 1, 0, 15, 1)); step_check("R5");

    // R6 gates
    one_slot(5, mk(1, 1, 1, 0, 0, 0));
    dbg_ctrl = 32'hFFFF_7FFF; step_check("R6");
    dbg_ctrl = 32'h0000_8000; dbg_allowed = 0; step_check("R6");
    dbg_allowed = 1; step_check("R6");

    // R8 invalid level, also with unprivileged data access
    for (int el = 4; el < 8; el++) begin
      cur_el = EW'(el); wp_unpriv = el[0];
      one_slot(2, mk(1, 1, 1, 0, 0, 0)); step_check("R8");
    end
    wp_unpriv = 0;

    // R7 lowest qualified, lower slots rejected by distinct rules
    cur_el = 1; secure = 1; ctx_match = 6'b000001;
    bp_hit = '1; wp_hit = '1;
    bp_ctrl = {mk(1,1,1,0,0,0), mk(1,1,1,0,0,0), mk(1,1,1,0,0,1),
               mk(1,1,1,0,1,1), mk(1,1,1,1,0,0), mk(1,0,1,0,0,0)};
    wp_ctrl = {mk(1,1,1,0,0,0), mk(1,1,1,0,0,0), mk(1,1,1,0,0,0),
               mk(1,1,1,3,0,0), mk(1,1,1,2,0,0), mk(1,0,0,0,0,0)};
    step_check("R7");
    bp_hit = 6'b110000; step_check("R7");
    bp_hit = '0; wp_hit = '0; step_check("R9");

    // R9 latency: change inputs, check result only after one edge
    secure = 0; cur_el = 1;
    one_slot(4, mk(1, 1, 1, 0, 0, 0)); step_check("R9");

    for (int k = 0; k < 600; k++) begin
      bp_hit = N'($urandom); wp_hit = N'($urandom);
      ctx_match = N'($urandom);
      for (int s = 0; s < N; s++) begin
        bp_ctrl[s*CW +: CW] = $urandom;
        wp_ctrl[s*CW +: CW] = $urandom;
      end
      cur_el = ($urandom_range(0, 9) == 0) ? EW'($urandom_range(4, 7)) : EW'($urandom_range(0, 3));
      secure = 1'($urandom); wp_unpriv = 1'($urandom);
      dbg_allowed = ($urandom_range(0, 9) != 0);
      dbg_ctrl = $urandom;
      if ($urandom_range(0, 9) != 0) dbg_ctrl[15] = 1'b1;
      step_check("R7");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule